// File: doc/BRIEF.md
# Port Control Line 2 Output Generator

This block produces the level of a port's second control line. A single state bit holds the line level, where 1 means high or released and 0 means low. A small control register written by the bus selects what the state bit does. With the direction bit clear, the line is an input and the state bit is held released. With the direction bit set, two mode bits choose among three behaviours. In manual mode the line follows a bit written by software. In handshake mode a port access pulls the line low and an active edge reported on control line 1 releases it. In pulse mode each port access produces a one-cycle low strobe.

A parameter picks the pin style, and the style also fixes which port access triggers the line. The open-drain style serves the first port: it only ever pulls the pin low, relies on an external pull-up for high, and is triggered by a port read. The push/pull style serves the second port: it drives the state level whenever the line is an output, and is triggered by a port write. Edge detection on control line 1 happens outside this block and arrives as a single-cycle strobe. Every clock is one bus cycle.

Top module: `cl2_line_out`

## Requirements
- R1: Write data bit 5 is the direction bit, bit 4 is mode select high and bit 3 is mode select low. All other bits of a control write have no effect on the line.
- R2: While bit 5 is 0, the line is released. Port accesses and line 1 edges change nothing. A write that clears bit 5 releases a line that was low, from the next cycle.
- R3: In the open-drain style, pin_out is always 0 and pin_oe is 1 only when bit 5 is 1 and the state is low.
- R4: In the push/pull style, pin_oe equals bit 5 and pin_out equals the state bit.
- R5: With bits 5 and 4 set (manual mode), the line level equals bit 3 from the cycle after the control write.
- R6: With bit 5 = 1 and bits 4 and 3 = 0 (handshake mode), a triggering port access drives the line low from the next cycle. A line 1 edge strobe drives it high from the next cycle. Otherwise the level holds.
- R7: With bit 5 = 1, bit 4 = 0 and bit 3 = 1 (pulse mode), the line is low in exactly the cycle after each triggering access and high otherwise. Back-to-back accesses keep it low.
- R8: Synchronous reset clears the control register, so the line is an input and released in the cycle after reset.
- R9: The open-drain style is triggered only by port_rd and ignores port_wr. The push/pull style is triggered only by port_wr and ignores port_rd.
- R10: In handshake mode, a triggering access and a line 1 edge in the same cycle leave the line low.
- R11: A control write in the same cycle as an access or edge takes effect in that cycle, so the new settings decide the next level.
- R12: Writing handshake mode leaves the current level unchanged. A line held low in manual mode stays low until a line 1 edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | CTRL_W | Control write data (bits 5, 4 and 3 are used) |
| port_rd | input | 1 | Port data read strobe (trigger for the open-drain style) |
| port_wr | input | 1 | Port data write strobe (trigger for the push/pull style) |
| line1_edge | input | 1 | Active edge reported on control line 1, one cycle wide |
| pin_out | output | 1 | Level presented to the pad driver |
| pin_oe | output | 1 | Pad driver enable |

## Verification
The assertions check every cycle that an input-mode line is released and that a handshake trigger always lands low. They also check that an idle handshake line holds, that pulse mode releases unless an access arrived, that manual mode tracks the written bit, and that reset leaves the pad undriven. Other behaviours can only be shown by running both pin styles side by side under one stimulus stream against a behavioural reference: ignoring the other port's strobe, ignoring unused control bits, the access-over-edge priority, and the same-cycle interplay of control writes with accesses.

// File: rtl/cl2_pkg.sv
package cl2_pkg;

    // Pin style; the style also selects which port access triggers the line
    typedef enum logic {
        PIN_OPEN_DRAIN = 1'b0,
        PIN_PUSH_PULL  = 1'b1
    } pin_kind_e;

    // Control bit positions (behavioural: software writes these)
    localparam int unsigned BIT_DIR  = 5;
    localparam int unsigned BIT_SELH = 4;
    localparam int unsigned BIT_SELL = 3;

    typedef struct packed {
        logic dir;
        logic selh;
        logic sell;
    } line_cfg_t;

    typedef enum logic [1:0] {
        LM_RELEASED  = 2'd0,
        LM_MANUAL    = 2'd1,
        LM_HANDSHAKE = 2'd2,
        LM_PULSE     = 2'd3
    } line_mode_e;

    function automatic line_mode_e mode_of(input line_cfg_t c);
        if (!c.dir)      return LM_RELEASED;
        else if (c.selh) return LM_MANUAL;
        else if (c.sell) return LM_PULSE;
        else             return LM_HANDSHAKE;
    endfunction

    // Next level of the state bit (1 = high / released)
    function automatic logic next_level(input line_cfg_t c, input logic cur,
                                        input logic trig, input logic edge_seen);
        logic n;
        n = cur;
        unique case (mode_of(c))
            LM_RELEASED:  n = 1'b1;
            LM_MANUAL:    n = c.sell;
            LM_PULSE:     n = ~trig;
            LM_HANDSHAKE: begin
                if (trig)           n = 1'b0;
                else if (edge_seen) n = 1'b1;
            end
            default:      n = 1'b1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cl2_cfg_reg.sv
module cl2_cfg_reg
    import cl2_pkg::*;
#(
    parameter int unsigned CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output line_cfg_t         cfg_q,
    output line_cfg_t         cfg_eff
);
    line_cfg_t cfg_new;

    assign cfg_new.dir  = wdata[BIT_DIR];
    assign cfg_new.selh = wdata[BIT_SELH];
    assign cfg_new.sell = wdata[BIT_SELL];

    // Settings that govern this cycle's update: a write applies at once
    assign cfg_eff = we ? cfg_new : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_eff;
    end

    // Only the three configuration bits are held
    logic unused_wbits;
    always_comb begin
        unused_wbits = 1'b0;
        for (int i = 0; i < int'(CTRL_W); i++) begin
            if (i != int'(BIT_DIR) && i != int'(BIT_SELH) && i != int'(BIT_SELL))
                unused_wbits = unused_wbits ^ wdata[i];
        end
    end

    // R1: the stored direction follows a write
    a_r1_dir_stored: assert property (@(posedge clk) disable iff (rst)
        we |=> cfg_q.dir == $past(wdata[BIT_DIR]));

    // R1: without a write the configuration holds
    a_r1_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg_q));
endmodule

// File: rtl/cl2_level_fsm.sv
module cl2_level_fsm
    import cl2_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_cfg_t cfg_eff,
    input  logic      trig,
    input  logic      edge_seen,
    output logic      level_q
);
    line_mode_e mode_eff;
    logic       level_d;

    assign mode_eff = mode_of(cfg_eff);
    assign level_d  = next_level(cfg_eff, level_q, trig, edge_seen);

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b1;
        else     level_q <= level_d;
    end

    a_r2_input_released: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == LM_RELEASED) |=> level_q);

    a_r5_manual_tracks: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == LM_MANUAL) |=> level_q == $past(cfg_eff.sell));

    // R6 and R10: a trigger always lands low, even with an edge
    a_r6_handshake_low: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == LM_HANDSHAKE && trig) |=> !level_q);

    a_r6_handshake_rise: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == LM_HANDSHAKE && !trig && edge_seen) |=> level_q);

    a_r12_handshake_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == LM_HANDSHAKE && !trig && !edge_seen) |=> $stable(level_q));

    a_r7_pulse_release: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == LM_PULSE && !trig) |=> level_q);

    a_r7_pulse_low: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == LM_PULSE && trig) |=> !level_q);
endmodule

// File: rtl/cl2_pin_drv.sv
module cl2_pin_drv
    import cl2_pkg::*;
#(
    parameter pin_kind_e PIN_KIND = PIN_OPEN_DRAIN
) (
    input  logic dir,
    input  logic level,
    output logic pin_out,
    output logic pin_oe
);
    generate
        if (PIN_KIND == PIN_OPEN_DRAIN) begin : g_od
            // Only ever sinks; the external pull-up supplies the high level
            assign pin_out = 1'b0;
            assign pin_oe  = dir & ~level;
        end else begin : g_pp
            assign pin_out = level;
            assign pin_oe  = dir;
        end
    endgenerate

    // R3: the released state never enables the pad driver in open-drain style
    always_comb begin
        if (PIN_KIND == PIN_OPEN_DRAIN && level)
            a_r3_od_release: assert (!pin_oe);
    end
endmodule

// File: rtl/cl2_line_out.sv
module cl2_line_out
    import cl2_pkg::*;
#(
    parameter pin_kind_e   PIN_KIND = PIN_OPEN_DRAIN,
    parameter int unsigned CTRL_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              port_rd,
    input  logic              port_wr,
    input  logic              line1_edge,
    output logic              pin_out,
    output logic              pin_oe
);
    line_cfg_t cfg_q;
    line_cfg_t cfg_eff;
    logic      trig;
    logic      level_q;

    generate
        if (PIN_KIND == PIN_OPEN_DRAIN) begin : g_trig_rd
            assign trig = port_rd;
            logic unused_wr;
            assign unused_wr = port_wr;
        end else begin : g_trig_wr
            assign trig = port_wr;
            logic unused_rd;
            assign unused_rd = port_rd;
        end
    endgenerate

    cl2_cfg_reg #(.CTRL_W(CTRL_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (ctrl_we),
        .wdata   (ctrl_wdata),
        .cfg_q   (cfg_q),
        .cfg_eff (cfg_eff)
    );

    cl2_level_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cfg_eff   (cfg_eff),
        .trig      (trig),
        .edge_seen (line1_edge),
        .level_q   (level_q)
    );

    cl2_pin_drv #(.PIN_KIND(PIN_KIND)) u_drv (
        .dir     (cfg_q.dir),
        .level   (level_q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    a_r8_reset_undriven: assert property (@(posedge clk)
        rst |=> !pin_oe);

    a_r2_dir_gates_oe: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && !ctrl_wdata[BIT_DIR]) |=> !pin_oe);
endmodule

// File: tb/sim_cl2_line_out.sv
`timescale 1ns/1ps
module sim_cl2_line_out;
    import cl2_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       port_rd = 1'b0, port_wr = 1'b0, line1_edge = 1'b0;
    logic       od_out, od_oe, pp_out, pp_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    string cur_req = "R8";

    always #2 clk = ~clk;

    cl2_line_out #(.PIN_KIND(PIN_OPEN_DRAIN), .CTRL_W(8)) u0 (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .port_rd(port_rd), .port_wr(port_wr), .line1_edge(line1_edge),
        .pin_out(od_out), .pin_oe(od_oe));

    cl2_line_out #(.PIN_KIND(PIN_PUSH_PULL), .CTRL_W(8)) u1 (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .port_rd(port_rd), .port_wr(port_wr), .line1_edge(line1_edge),
        .pin_out(pp_out), .pin_oe(pp_oe));

    // Reference state: configuration integers and one level per style
    int m_dir = 0, m_hi = 0, m_lo = 0;
    int lvl_a = 1, lvl_b = 1;

    function automatic int ref_next(int lvl, int acc);
        if (m_dir == 0) return 1;                    // R2
        if (m_hi == 1)  return m_lo;                 // R5
        if (m_lo == 1)  return (acc != 0) ? 0 : 1;   // R7
        if (acc != 0)   return 0;                    // R6, R10
        if (line1_edge) return 1;
        return lvl;                                  // R12
    endfunction

    task automatic check(input string req, input logic act, input int exp, input string what);
        checks++;
        if (act !== exp[0]) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One bus cycle: inputs already driven; update model at edge; compare after
    task automatic step();
        @(posedge clk);
        if (rst) begin
            m_dir = 0; m_hi = 0; m_lo = 0; lvl_a = 1; lvl_b = 1;
        end else begin
            if (ctrl_we) begin                       // R1, R11
                m_dir = int'(ctrl_wdata[5]);
                m_hi  = int'(ctrl_wdata[4]);
                m_lo  = int'(ctrl_wdata[3]);
            end
            lvl_a = ref_next(lvl_a, int'(port_rd));  // R9
            lvl_b = ref_next(lvl_b, int'(port_wr));
        end
        @(negedge clk);
        check(cur_req, od_out, 0, "od pin_out");                                    // R3
        check(cur_req, od_oe, (m_dir == 1 && lvl_a == 0) ? 1 : 0, "od pin_oe");    // R3
        check(cur_req, pp_oe, m_dir, "pp pin_oe");                                  // R4
        check(cur_req, pp_out, lvl_b, "pp pin_out");                                // R4
        ctrl_we = 0; port_rd = 0; port_wr = 0; line1_edge = 0;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_we = 1; ctrl_wdata = v; step();
    endtask

    task automatic bus(input logic rd, input logic wr, input logic e);
        port_rd = rd; port_wr = wr; line1_edge = e; step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        @(negedge clk);
        cur_req = "R8"; rst = 1; step(); step(); rst = 0; idle(2);

        cur_req = "R2";
        bus(1, 1, 0); bus(0, 0, 1); bus(1, 0, 1); idle(1);

        cur_req = "R5";
        wr_ctrl(8'h30); idle(1); wr_ctrl(8'h38); idle(1); wr_ctrl(8'h30);

        cur_req = "R1";
        wr_ctrl(8'hF7); idle(1); wr_ctrl(8'hCF); idle(1);   // dir/hi/lo from bits 5,4,3
        wr_ctrl(8'hC7); bus(1, 1, 0);

        cur_req = "R12";
        wr_ctrl(8'h30); wr_ctrl(8'h20); idle(2); bus(0, 0, 1); idle(1);

        cur_req = "R6";
        bus(1, 0, 0); idle(2); bus(0, 0, 1); bus(0, 1, 0); idle(2); bus(0, 0, 1);

        cur_req = "R9";
        bus(0, 1, 0); idle(1); bus(1, 0, 0); idle(1); bus(0, 0, 1); bus(0, 0, 1);

        cur_req = "R10";
        bus(1, 1, 1); idle(1); bus(0, 0, 1); idle(1);

        cur_req = "R7";
        wr_ctrl(8'h28); bus(1, 1, 0); idle(2); bus(1, 0, 0); bus(0, 1, 0);
        bus(1, 1, 0); bus(1, 1, 0); bus(1, 1, 1); idle(2);

        cur_req = "R11";
        ctrl_we = 1; ctrl_wdata = 8'h20; port_rd = 1; port_wr = 1; step(); idle(1);
        ctrl_we = 1; ctrl_wdata = 8'h00; line1_edge = 1; step();
        wr_ctrl(8'h20); bus(1, 1, 0);
        ctrl_we = 1; ctrl_wdata = 8'h00; step(); idle(1);

        cur_req = "R2";
        wr_ctrl(8'h30); ctrl_we = 1; ctrl_wdata = 8'h18; step(); idle(1);

        cur_req = "R8";
        wr_ctrl(8'h30); rst = 1; step(); rst = 0; idle(2);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule